// File: doc/BRIEF.md
# Link Startup and Capability Exchange Monitor

This block is a passive protocol checker that sits beside a link receiver and watches a stream of already decoded link events. Each event arrives as a one-cycle valid strobe with a 4-bit type code. The monitor follows the link through five startup phases driven by trigger symbols, then through the capability exchange burst, and finally into data link initialisation. Every event it judges produces one finding: a code and a severity. A current-phase output and a vector of sticky failure flags are also provided. The monitor never drives the link.

A free-running timebase divides the clock into ticks with a programmable period. It counts the ticks since the most recent phase-0 trigger. Each phase-0 trigger that follows an earlier one is compared against a programmable activate threshold, counted in ticks. A gap shorter than the threshold is a timing failure. During the capability exchange, only the burst delimiters and the two capability indications are legal. They must appear in this order: open burst, extended capability, basic capability, close burst.

State machine (state register `st`). The names give the transitions that advance it:
ST_PH0 --TRG1--> ST_PH1 --TRG2--> ST_PH2 --TRG0--> ST_PH3 --TRG1--> ST_PH4 --EOB--> ST_CX_SOB --SOB--> ST_CX_EXT --CAP_EXT--> ST_CX_BAS --CAP_BASIC--> ST_CX_EOB --EOB--> ST_DLINIT.
Every other event leaves the state unchanged. ST_DLINIT is absorbing until reset.

Top module: `lss_monitor`

## Requirements
- R1: A synchronous reset (`rst` high) puts the monitor in phase 0, clears `find_valid` and clears every bit of `err_sticky`. Phase encoding: PH0..PH4 give 0..4, every exchange sub-state gives 5, and data link initialisation gives 6. Severity encoding: Failure 0, Warning 1, Pass 2, Info 3, Debug 4.
- R2: Findings are registered. The finding for an event sampled at clock edge e is visible after edge e. Event type codes: TRG0=0, TRG1=1, TRG2=2, SOB=3, EOB=4, CAP_EXT=5, CAP_BASIC=6, FC_TC0=7, FC_TC1=8, OTHER=9. Codes 10 to 15 are treated as OTHER.
- R3: One tick occurs every `cfg_tick_div` clocks, and a value of 0 acts as 1. Every TRG0 restarts the divider and the tick count. For two TRG0 events N clocks apart, the measured gap is floor((N-1)/div) ticks.
- R4: In phase 0, a TRG0 whose gap to the previous TRG0 is less than the threshold gives code 1 (spacing) with Failure. Any other TRG0 in phase 0 gives code 11 with Debug. This includes the first TRG0 after reset, which is not checked.
- R5: A `cfg_act_ticks` value of 0 selects the threshold DEF_ACT_TICKS (default 1600, which is 1.6 ms at a 1 us tick).
- R6: The startup advance follows the diagram and gives code 8 with Info. In PH1 to PH4, a repeat of the trigger that entered the phase gives no finding. Any other trigger, SOB, CAP or EOB before the exchange gives code 2 (order) with Failure.
- R7: An EOB in PH4 enters the exchange (phase 5) with code 9 and Info. The accepted steps SOB, CAP_EXT and CAP_BASIC each give code 12 with Info.
- R8: An EOB after the basic capability enters data link initialisation (phase 6) with code 10 and Pass.
- R9: FC_TC0 or FC_TC1 seen before phase 6 gives code 4 with Failure and leaves the state unchanged.
- R10: An OTHER packet before phase 6, or any trigger during the exchange, gives code 3 with Failure.
- R11: A CAP_BASIC while the extended capability is expected gives code 5 with Failure, and the exchange stays waiting for CAP_EXT. A capability before the exchange burst opens gives code 7 with Failure. A misplaced SOB, EOB or repeated CAP_EXT inside the exchange gives code 2.
- R12: Once CAP_BASIC is accepted, any packet other than EOB, a flow-control frame or OTHER gives code 6 with Failure.
- R13: Every Failure with code c sets `err_sticky[c]`. Sticky bits stay set until reset.
- R14: In phase 6 no event produces a finding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_tick_div | input | 8 | Clocks per timebase tick (0 acts as 1) |
| cfg_act_ticks | input | 16 | Minimum TRG0 spacing in ticks (0 selects the default) |
| ev_valid | input | 1 | Event strobe |
| ev_type | input | 4 | Event type code |
| find_valid | output | 1 | A finding is present this cycle |
| find_code | output | 4 | Finding code |
| find_sev | output | 3 | Finding severity |
| phase | output | 3 | Current phase |
| err_sticky | output | 8 | Sticky failure flags, indexed by code |

## Verification
The bench sweeps the TRG0 gap clock by clock across the threshold, at a divider of 4 and again at a divider of 0. An off-by-one in the divider restart or in the comparison would move the pass/fail boundary by one clock. The default threshold is exercised at exactly 1600 and 1601 clocks, which exposes a wrong zero-select. Each illegal packet is driven in the startup phases and in every exchange sub-state, covering reversed capabilities, capabilities before the burst opens, a missing close after the basic capability, flow-control frames and unknown codes. A design that advanced on these events, or gave them the wrong code, would report a wrong phase or code on the following check. Sticky flags are compared as a whole vector before and after reset, and phase 6 is probed for silence.

// File: rtl/lss_pkg.sv
package lss_pkg;

    typedef enum logic [3:0] {
        EV_TRG0      = 4'd0,
        EV_TRG1      = 4'd1,
        EV_TRG2      = 4'd2,
        EV_SOB       = 4'd3,
        EV_EOB       = 4'd4,
        EV_CAP_EXT   = 4'd5,
        EV_CAP_BASIC = 4'd6,
        EV_FC0       = 4'd7,
        EV_FC1       = 4'd8,
        EV_OTHER     = 4'd9
    } ev_kind_e;

    typedef enum logic [2:0] {
        SEV_FAIL  = 3'd0,
        SEV_WARN  = 3'd1,
        SEV_PASS  = 3'd2,
        SEV_INFO  = 3'd3,
        SEV_DEBUG = 3'd4
    } sev_e;

    typedef enum logic [3:0] {
        FC_NONE        = 4'd0,
        FC_TRG_SPACING = 4'd1,
        FC_SEQ_ORDER   = 4'd2,
        FC_ILLEGAL     = 4'd3,
        FC_FLOW_EARLY  = 4'd4,
        FC_CAP_SWAP    = 4'd5,
        FC_CAP_NO_EOB  = 4'd6,
        FC_CAP_NO_SOB  = 4'd7,
        FC_PHASE_ADV   = 4'd8,
        FC_EXCH_START  = 4'd9,
        FC_EXCH_DONE   = 4'd10,
        FC_TRG_OK      = 4'd11,
        FC_EXCH_STEP   = 4'd12
    } find_e;

    typedef enum logic [3:0] {
        ST_PH0,
        ST_PH1,
        ST_PH2,
        ST_PH3,
        ST_PH4,
        ST_CX_SOB,
        ST_CX_EXT,
        ST_CX_BAS,
        ST_CX_EOB,
        ST_DLINIT
    } state_e;

    typedef struct packed {
        logic  v;
        find_e c;
        sev_e  s;
    } finding_t;

    localparam int unsigned N_FAIL_CODES = 8;
    localparam int unsigned EV_W         = 4;
    localparam int unsigned PHASE_W      = 3;
    localparam int unsigned LAST_KIND    = 9;

endpackage

// File: rtl/lss_classify.sv
module lss_classify
    import lss_pkg::*;
(
    input  logic [EV_W-1:0] raw_type,
    output ev_kind_e        kind
);
    always_comb begin
        if (int'(raw_type) <= LAST_KIND) kind = ev_kind_e'(raw_type);
        else                             kind = EV_OTHER;
    end
endmodule

// File: rtl/lss_timebase.sv
module lss_timebase #(
    parameter int unsigned TDIV_W        = 8,
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned DEF_ACT_TICKS = 1600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TDIV_W-1:0] cfg_div,
    input  logic [CNT_W-1:0]  cfg_thr,
    input  logic              restart,
    output logic              gap_short,
    output logic              armed
);
    localparam logic [CNT_W-1:0]  DEF_THR = CNT_W'(DEF_ACT_TICKS);
    localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
    localparam logic [TDIV_W-1:0] ONE_DIV = TDIV_W'(1);

    logic [TDIV_W-1:0] pre;
    logic [CNT_W-1:0]  ticks;
    logic [TDIV_W-1:0] eff_div;
    logic [CNT_W-1:0]  thr;
    logic              tick;

    always_comb begin
        eff_div = (cfg_div == '0) ? ONE_DIV : cfg_div;
        tick    = (pre >= eff_div - ONE_DIV);
        thr     = (cfg_thr == '0) ? DEF_THR : cfg_thr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre   <= '0;
            ticks <= '0;
            armed <= 1'b0;
        end else if (restart) begin
            pre   <= '0;
            ticks <= '0;
            armed <= 1'b1;
        end else if (tick) begin
            pre <= '0;
            if (ticks != CNT_MAX) ticks <= ticks + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assign gap_short = (ticks < thr);

    p_gap_restart_r3: assert property (@(posedge clk) disable iff (rst)
        $past(restart) |-> (ticks == '0));

    p_gap_mono_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(restart) |-> (ticks >= $past(ticks)));

endmodule

// File: rtl/lss_fsm.sv
module lss_fsm
    import lss_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ev_valid,
    input  ev_kind_e                ev_kind,
    input  logic                    gap_short,
    input  logic                    armed,
    output logic                    find_valid,
    output logic [3:0]              find_code,
    output logic [2:0]              find_sev,
    output logic [PHASE_W-1:0]      phase,
    output logic [N_FAIL_CODES-1:0] sticky
);
    state_e   st, nxt;
    finding_t fnd;

    function automatic finding_t mk(input find_e c, input sev_e s);
        finding_t f;
        f.v = 1'b1;
        f.c = c;
        f.s = s;
        return f;
    endfunction

    function automatic finding_t fail(input find_e c);
        return mk(c, SEV_FAIL);
    endfunction

    logic is_trg, in_cx;
    always_comb begin
        is_trg = (ev_kind == EV_TRG0) || (ev_kind == EV_TRG1) || (ev_kind == EV_TRG2);
        in_cx  = (st == ST_CX_SOB) || (st == ST_CX_EXT) ||
                 (st == ST_CX_BAS) || (st == ST_CX_EOB);
    end

    // next state and finding
    always_comb begin
        nxt = st;
        fnd = '{v: 1'b0, c: FC_NONE, s: SEV_DEBUG};
        if (ev_valid && st != ST_DLINIT) begin
            if (ev_kind == EV_FC0 || ev_kind == EV_FC1) begin
                fnd = fail(FC_FLOW_EARLY);
            end else if (ev_kind == EV_OTHER || (in_cx && is_trg)) begin
                fnd = fail(FC_ILLEGAL);
            end else begin
                unique case (st)
                    ST_PH0: begin
                        if (ev_kind == EV_TRG0) begin
                            fnd = (armed && gap_short) ? fail(FC_TRG_SPACING)
                                                       : mk(FC_TRG_OK, SEV_DEBUG);
                        end else if (ev_kind == EV_TRG1) begin
                            nxt = ST_PH1;
                            fnd = mk(FC_PHASE_ADV, SEV_INFO);
                        end else begin
                            fnd = fail(FC_SEQ_ORDER);
                        end
                    end
                    ST_PH1: begin
                        if (ev_kind == EV_TRG2) begin
                            nxt = ST_PH2;
                            fnd = mk(FC_PHASE_ADV, SEV_INFO);
                        end else if (ev_kind != EV_TRG1) begin
                            fnd = fail(FC_SEQ_ORDER);
                        end
                    end
                    ST_PH2: begin
                        if (ev_kind == EV_TRG0) begin
                            nxt = ST_PH3;
                            fnd = mk(FC_PHASE_ADV, SEV_INFO);
                        end else if (ev_kind != EV_TRG2) begin
                            fnd = fail(FC_SEQ_ORDER);
                        end
                    end
                    ST_PH3: begin
                        if (ev_kind == EV_TRG1) begin
                            nxt = ST_PH4;
                            fnd = mk(FC_PHASE_ADV, SEV_INFO);
                        end else if (ev_kind != EV_TRG0) begin
                            fnd = fail(FC_SEQ_ORDER);
                        end
                    end
                    ST_PH4: begin
                        if (ev_kind == EV_EOB) begin
                            nxt = ST_CX_SOB;
                            fnd = mk(FC_EXCH_START, SEV_INFO);
                        end else if (ev_kind != EV_TRG1) begin
                            fnd = fail(FC_SEQ_ORDER);
                        end
                    end
                    ST_CX_SOB: begin
                        if (ev_kind == EV_SOB) begin
                            nxt = ST_CX_EXT;
                            fnd = mk(FC_EXCH_STEP, SEV_INFO);
                        end else if (ev_kind == EV_CAP_EXT || ev_kind == EV_CAP_BASIC) begin
                            fnd = fail(FC_CAP_NO_SOB);
                        end else begin
                            fnd = fail(FC_SEQ_ORDER);
                        end
                    end
                    ST_CX_EXT: begin
                        if (ev_kind == EV_CAP_EXT) begin
                            nxt = ST_CX_BAS;
                            fnd = mk(FC_EXCH_STEP, SEV_INFO);
                        end else if (ev_kind == EV_CAP_BASIC) begin
                            fnd = fail(FC_CAP_SWAP);
                        end else begin
                            fnd = fail(FC_SEQ_ORDER);
                        end
                    end
                    ST_CX_BAS: begin
                        if (ev_kind == EV_CAP_BASIC) begin
                            nxt = ST_CX_EOB;
                            fnd = mk(FC_EXCH_STEP, SEV_INFO);
                        end else begin
                            fnd = fail(FC_SEQ_ORDER);
                        end
                    end
                    ST_CX_EOB: begin
                        if (ev_kind == EV_EOB) begin
                            nxt = ST_DLINIT;
                            fnd = mk(FC_EXCH_DONE, SEV_PASS);
                        end else begin
                            fnd = fail(FC_CAP_NO_EOB);
                        end
                    end
                    default: begin
                        nxt = st;
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_PH0;
        else     st <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            find_valid <= 1'b0;
            find_code  <= FC_NONE;
            find_sev   <= SEV_DEBUG;
        end else begin
            find_valid <= fnd.v;
            find_code  <= fnd.c;
            find_sev   <= fnd.s;
        end
    end

    generate
        for (genvar i = 0; i < N_FAIL_CODES; i++) begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst)
                    sticky[i] <= 1'b0;
                else if (fnd.v && fnd.s == SEV_FAIL && int'(fnd.c) == i)
                    sticky[i] <= 1'b1;
            end
        end
    endgenerate

    always_comb begin
        unique case (st)
            ST_PH0:    phase = 3'd0;
            ST_PH1:    phase = 3'd1;
            ST_PH2:    phase = 3'd2;
            ST_PH3:    phase = 3'd3;
            ST_PH4:    phase = 3'd4;
            ST_DLINIT: phase = 3'd6;
            default:   phase = 3'd5;
        endcase
    end

    p_dl_absorb_r14: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DLINIT) |=> (st == ST_DLINIT));

    p_done_from_eob_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DLINIT && $past(st) != ST_DLINIT) |->
            ($past(st) == ST_CX_EOB && $past(ev_kind) == EV_EOB && $past(ev_valid)));

    p_flow_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && (ev_kind == EV_FC0 || ev_kind == EV_FC1)) |=> $stable(st));

    p_find_needs_ev_r2: assert property (@(posedge clk) disable iff (rst)
        find_valid |-> $past(ev_valid));

    p_sticky_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (sticky & $past(sticky)) == $past(sticky));

    p_fail_sets_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        (find_valid && find_sev == SEV_FAIL) |->
            (find_code < 4'd8 && sticky[find_code[2:0]]));

endmodule

// File: rtl/lss_monitor.sv
module lss_monitor
    import lss_pkg::*;
#(
    parameter int unsigned TDIV_W        = 8,
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned DEF_ACT_TICKS = 1600
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [TDIV_W-1:0]       cfg_tick_div,
    input  logic [CNT_W-1:0]        cfg_act_ticks,
    input  logic                    ev_valid,
    input  logic [EV_W-1:0]         ev_type,
    output logic                    find_valid,
    output logic [3:0]              find_code,
    output logic [2:0]              find_sev,
    output logic [PHASE_W-1:0]      phase,
    output logic [N_FAIL_CODES-1:0] err_sticky
);
    ev_kind_e kind;
    logic     gap_short;
    logic     armed;
    logic     restart;

    lss_classify u_classify (
        .raw_type (ev_type),
        .kind     (kind)
    );

    assign restart = ev_valid && (kind == EV_TRG0);

    lss_timebase #(
        .TDIV_W        (TDIV_W),
        .CNT_W         (CNT_W),
        .DEF_ACT_TICKS (DEF_ACT_TICKS)
    ) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .cfg_div   (cfg_tick_div),
        .cfg_thr   (cfg_act_ticks),
        .restart   (restart),
        .gap_short (gap_short),
        .armed     (armed)
    );

    lss_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ev_valid   (ev_valid),
        .ev_kind    (kind),
        .gap_short  (gap_short),
        .armed      (armed),
        .find_valid (find_valid),
        .find_code  (find_code),
        .find_sev   (find_sev),
        .phase      (phase),
        .sticky     (err_sticky)
    );

endmodule

// File: tb/test_lss_monitor.sv
module test_lss_monitor;
    localparam int CLK_PERIOD = 10;

    localparam int T_TRG0 = 0, T_TRG1 = 1, T_TRG2 = 2, T_SOB = 3, T_EOB = 4;
    localparam int T_CEXT = 5, T_CBAS = 6, T_FC0 = 7, T_FC1 = 8, T_OTH = 9;
    localparam int S_FAIL = 0, S_PASS = 2, S_INFO = 3, S_DEBUG = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_tick_div = 8'd0;
    logic [15:0] cfg_act_ticks = 16'd0;
    logic       ev_valid = 1'b0;
    logic [3:0] ev_type = 4'd0;
    logic       find_valid;
    logic [3:0] find_code;
    logic [2:0] find_sev;
    logic [2:0] phase;
    logic [7:0] err_sticky;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lss_monitor i_lss_monitor (
        .clk           (clk),
        .rst           (rst),
        .cfg_tick_div  (cfg_tick_div),
        .cfg_act_ticks (cfg_act_ticks),
        .ev_valid      (ev_valid),
        .ev_type       (ev_type),
        .find_valid    (find_valid),
        .find_code     (find_code),
        .find_sev      (find_sev),
        .phase         (phase),
        .err_sticky    (err_sticky)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // called at a negedge: drives one event for the next posedge
    task automatic ev(input int t);
        ev_valid = 1'b1;
        ev_type  = 4'(t);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic find(input string tag, input int v, input int c, input int s, input int ph);
        chk({tag, " valid"}, int'(find_valid), v);
        if (v != 0) begin
            chk({tag, " code"}, int'(find_code), c);
            chk({tag, " sev"}, int'(find_sev), s);
        end
        chk({tag, " phase"}, int'(phase), ph);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        idle(1);
        do_reset();
        // R1 reset state
        find("R1 reset", 0, 0, 0, 0);
        chk("R1 sticky clear", int'(err_sticky), 0);

        // R3 R4 gap sweep, div 4, threshold 5
        cfg_tick_div  = 8'd4;
        cfg_act_ticks = 16'd5;
        ev(T_TRG0);
        find("R4 first trg0 unchecked", 1, 11, S_DEBUG, 0);
        for (int n = 1; n <= 30; n++) begin
            idle(n - 1);
            ev(T_TRG0);
            if (((n - 1) / 4) < 5) find($sformatf("R3 R4 div4 gap %0d", n), 1, 1, S_FAIL, 0);
            else                   find($sformatf("R3 R4 div4 gap %0d", n), 1, 11, S_DEBUG, 0);
        end
        // R3 divider 0 acts as 1, threshold 3
        cfg_tick_div  = 8'd0;
        cfg_act_ticks = 16'd3;
        ev(T_TRG0);
        for (int n = 1; n <= 6; n++) begin
            idle(n - 1);
            ev(T_TRG0);
            if ((n - 1) < 3) find($sformatf("R3 div0 gap %0d", n), 1, 1, S_FAIL, 0);
            else             find($sformatf("R3 div0 gap %0d", n), 1, 11, S_DEBUG, 0);
        end
        chk("R13 sticky after spacing", int'(err_sticky), 8'h02);

        // R5 default threshold, R1 reset clears sticky
        do_reset();
        chk("R1 R13 sticky cleared", int'(err_sticky), 0);
        cfg_tick_div  = 8'd1;
        cfg_act_ticks = 16'd0;
        ev(T_TRG0);
        idle(1599);
        ev(T_TRG0);
        find("R5 default gap 1600", 1, 1, S_FAIL, 0);
        idle(1600);
        ev(T_TRG0);
        find("R5 default gap 1601", 1, 11, S_DEBUG, 0);

        // startup ordering
        do_reset();
        ev(T_TRG2);  find("R6 trg2 in ph0", 1, 2, S_FAIL, 0);
        ev(T_SOB);   find("R6 sob in ph0", 1, 2, S_FAIL, 0);
        ev(T_EOB);   find("R6 eob in ph0", 1, 2, S_FAIL, 0);
        ev(T_CEXT);  find("R6 cap in ph0", 1, 2, S_FAIL, 0);
        ev(T_FC0);   find("R9 fc0 in ph0", 1, 4, S_FAIL, 0);
        ev(T_OTH);   find("R10 other in ph0", 1, 3, S_FAIL, 0);
        ev(15);      find("R10 unknown code in ph0", 1, 3, S_FAIL, 0);
        ev(T_TRG1);  find("R6 ph0 to ph1", 1, 8, S_INFO, 1);
        ev(T_TRG1);  find("R6 repeat in ph1", 0, 0, 0, 1);
        ev(T_TRG0);  find("R6 trg0 in ph1", 1, 2, S_FAIL, 1);
        ev(T_TRG2);  find("R6 ph1 to ph2", 1, 8, S_INFO, 2);
        ev(T_TRG0);  find("R6 ph2 to ph3", 1, 8, S_INFO, 3);
        ev(T_TRG1);  find("R6 ph3 to ph4", 1, 8, S_INFO, 4);
        ev(T_FC1);   find("R9 fc1 in ph4", 1, 4, S_FAIL, 4);
        ev(T_EOB);   find("R7 exchange start", 1, 9, S_INFO, 5);

        // capability exchange
        ev(T_CEXT);  find("R11 cap before sob", 1, 7, S_FAIL, 5);
        ev(T_TRG0);  find("R10 trigger in exchange", 1, 3, S_FAIL, 5);
        ev(T_EOB);   find("R11 eob before sob", 1, 2, S_FAIL, 5);
        ev(T_SOB);   find("R7 sob step", 1, 12, S_INFO, 5);
        ev(T_CBAS);  find("R11 basic before ext", 1, 5, S_FAIL, 5);
        ev(T_SOB);   find("R11 sob in ext wait", 1, 2, S_FAIL, 5);
        ev(T_CEXT);  find("R7 R11 ext after swap", 1, 12, S_INFO, 5);
        ev(T_CEXT);  find("R11 ext repeated", 1, 2, S_FAIL, 5);
        ev(T_EOB);   find("R11 eob before basic", 1, 2, S_FAIL, 5);
        ev(T_CBAS);  find("R7 basic step", 1, 12, S_INFO, 5);
        ev(T_FC0);   find("R9 fc0 in exchange", 1, 4, S_FAIL, 5);
        ev(T_SOB);   find("R12 sob after basic", 1, 6, S_FAIL, 5);
        ev(T_CEXT);  find("R12 cap after basic", 1, 6, S_FAIL, 5);
        ev(T_OTH);   find("R10 other after basic", 1, 3, S_FAIL, 5);
        ev(T_EOB);   find("R8 exchange done", 1, 10, S_PASS, 6);

        // R14 silence in data link initialisation
        ev(T_FC0);   find("R14 fc0 in dl", 0, 0, 0, 6);
        ev(T_OTH);   find("R14 other in dl", 0, 0, 0, 6);
        ev(T_TRG0);  find("R14 trg0 in dl", 0, 0, 0, 6);
        ev(T_CBAS);  find("R14 cap in dl", 0, 0, 0, 6);

        chk("R13 sticky vector", int'(err_sticky), 8'hFC);
        do_reset();
        chk("R1 R13 sticky reset", int'(err_sticky), 0);
        find("R1 phase after reset", 0, 0, 0, 0);

        finish_run();
    end
endmodule